// File: doc/BRIEF.md
# Key Scan Debounce and Interrupt Unit

This unit watches up to twenty key lines and samples them only when a scan strobe arrives, once per key-scan window. Each key runs through a small per-key tracker. A key counts as a new press only when two strobes in a row find it pressed, and the strobe before that pair must have found it released. Each accepted press sets a sticky bit in a key-data image. Bits from later presses are ORed in, and there is no queue. An interrupt flag is raised with the first accepted key. Both the image and the flag stay set until the host finishes a block read of all three key bytes.

The image is presented as three bytes and a flag byte. An interrupt pin level and its output enable are derived from two configuration bits: one enables the pin and the other selects its polarity. A mode input limits scanning to sixteen keys when the panel runs with eight commons. In standby the unit holds the image and the flag at zero and keeps the pin inactive. It raises a wake request while any key that is scanned in the current mode is pressed.

Top module: `keyscan_irq`

## Requirements
- R1: After reset all three key bytes and the flag byte read 0x00, and the interrupt pin sits at its inactive level.
- R2: A key is accepted only when two consecutive scan strobes find it pressed after a strobe that found it released. A press seen on a single strobe, or on two strobes with a released strobe between them, is not accepted.
- R3: Accepted keys accumulate. Each acceptance ORs its bit into the key data, and no bit is cleared by a later press or release.
- R4: A key held down is accepted once. After a clear it is not accepted again while it stays held. It must be seen released before two more pressed strobes accept it again.
- R5: Key byte 0 carries keys 7..0 and key byte 1 carries keys 15..8, with the lowest key in bit 0. Key byte 2 carries keys 19..16 in bits 3..0, and bits 7..4 of key byte 2 are always 0.
- R6: Bit 7 of the flag byte is the interrupt flag. It is 1 exactly when at least one key has been accepted since the last clear. Bits 6..0 of the flag byte are always 0.
- R7: A block-read-complete pulse clears all key data and the flag. A key accepted on the same strobe as the pulse is kept.
- R8: The pin enable equals the pin-enable configuration bit. With the polarity bit at 0 the pin level is the inverted flag (active low). With the polarity bit at 1 the pin level equals the flag (active high).
- R9: With the eight-common mode bit set, keys 19..16 are never accepted.
- R10: While standby is high, key data and flag read 0, no key is accepted, and the pin level is inactive. The wake request is high exactly when a key that is scanned in the current mode is pressed.
- R11: Key level changes between scan strobes have no effect on the key data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_tick | input | 1 | One-cycle strobe that marks a key-scan sample |
| key_raw | input | 20 | Key levels, 1 = pressed |
| mode_8com | input | 1 | 1 = sixteen keys scanned, 0 = twenty keys |
| int_pin_en | input | 1 | 1 = pin carries the interrupt |
| int_act_high | input | 1 | Interrupt polarity, 1 = active high |
| standby | input | 1 | Standby request |
| block_read_done | input | 1 | Pulse when the three-byte key read completes |
| key_byte0 | output | 8 | Keys 7..0 |
| key_byte1 | output | 8 | Keys 15..8 |
| key_byte2 | output | 8 | Keys 19..16 in bits 3..0 |
| flag_byte | output | 8 | Interrupt flag in bit 7 |
| int_level | output | 1 | Interrupt pin level |
| int_oe | output | 1 | Interrupt pin output enable |
| wake_req | output | 1 | Wake request during standby |

## Verification
The hardest case to reach is a key that is still held after a clear. It sits in the reported state and must not be accepted again, so the stimulus keeps it pressed across a block read and several later strobes before it releases and presses it again. Another awkward case is a clear pulse that arrives on the same strobe as a fresh acceptance, which needs a key staged one strobe ahead. A sweep over every key in both modes checks the byte placement and the masking of the upper keys.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_ONCE = 2'd1,
        SLOT_HELD = 2'd2
    } slot_e;
endpackage

// File: rtl/key_slot.sv
module key_slot
    import keyscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic level,
    output logic accept
);
    slot_e st_q, st_d;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (tick) begin
            if (!enable) begin
                st_d = SLOT_IDLE;
            end else begin
                case (st_q)
                    SLOT_IDLE: if (level) st_d = SLOT_ONCE;
                    SLOT_ONCE: begin
                        if (level) begin
                            st_d   = SLOT_HELD;
                            accept = 1'b1;
                        end else begin
                            st_d = SLOT_IDLE;
                        end
                    end
                    SLOT_HELD: if (!level) st_d = SLOT_IDLE;
                    default:   st_d = SLOT_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_IDLE;
        else        st_q <= st_d;
    end

    // R4: an acceptance is never followed by another on the next cycle
    a_r4_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    // R2: acceptance needs the key pressed on the accepting strobe
    a_r2_pressed_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (tick && level && enable));
endmodule

// File: rtl/int_drive.sv
module int_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic pin_en,
    input  logic act_high,
    output logic level,
    output logic oe
);
    always_comb begin
        oe    = pin_en;
        level = act_high ? flag : ~flag;
    end

    // R8: with no flag the pin rests at the inactive level for the polarity
    a_r8_inactive_level: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (level == !act_high));
endmodule

// File: rtl/keyscan_irq.sv
module keyscan_irq
    import keyscan_pkg::*;
#(
    parameter int NUM_KEYS   = 20,
    parameter int KEYS_8COM  = 16,
    parameter int BYTE_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_tick,
    input  logic [NUM_KEYS-1:0] key_raw,
    input  logic                mode_8com,
    input  logic                int_pin_en,
    input  logic                int_act_high,
    input  logic                standby,
    input  logic                block_read_done,
    output logic [BYTE_W-1:0]   key_byte0,
    output logic [BYTE_W-1:0]   key_byte1,
    output logic [BYTE_W-1:0]   key_byte2,
    output logic [BYTE_W-1:0]   flag_byte,
    output logic                int_level,
    output logic                int_oe,
    output logic                wake_req
);
    localparam int IMG_W = 3 * BYTE_W;
    localparam int PAD_W = IMG_W - NUM_KEYS;

    typedef struct packed {
        logic [NUM_KEYS-1:0] data;
        logic                flag;
    } kstate_t;

    kstate_t             cur_q, nxt_d;
    logic [NUM_KEYS-1:0] key_en;
    logic [NUM_KEYS-1:0] accept_vec;
    logic [IMG_W-1:0]    image;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_slot
        assign key_en[i] = !mode_8com || (i < KEYS_8COM);
        key_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (scan_tick),
            .enable (key_en[i] && !standby),
            .level  (key_raw[i]),
            .accept (accept_vec[i])
        );
    end

    always_comb begin
        nxt_d = cur_q;
        if (standby) begin
            nxt_d.data = '0;
            nxt_d.flag = 1'b0;
        end else begin
            if (block_read_done) begin
                nxt_d.data = '0;
                nxt_d.flag = 1'b0;
            end
            nxt_d.data = nxt_d.data | accept_vec;
            if (|accept_vec) nxt_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign image     = {{PAD_W{1'b0}}, cur_q.data};
    assign key_byte0 = image[BYTE_W-1:0];
    assign key_byte1 = image[2*BYTE_W-1:BYTE_W];
    assign key_byte2 = image[3*BYTE_W-1:2*BYTE_W];
    assign flag_byte = {cur_q.flag, {(BYTE_W-1){1'b0}}};
    assign wake_req  = standby && |(key_raw & key_en);

    int_drive u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (cur_q.flag),
        .pin_en   (int_pin_en),
        .act_high (int_act_high),
        .level    (int_level),
        .oe       (int_oe)
    );

    // R11: without a strobe, clear or standby the key data holds
    a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && !block_read_done && !standby) |=> $stable(cur_q.data));
    // R9: upper keys are never accepted in eight-common mode
    a_r9_upper_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mode_8com |-> (accept_vec[NUM_KEYS-1:KEYS_8COM] == '0));
    // R6: flag register and key data agree on whether anything is pending
    a_r6_flag_matches_data: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.flag == (|cur_q.data));
    // R10: standby empties key data and flag on the next cycle
    a_r10_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (cur_q.data == '0 && !cur_q.flag));
    // R7: a clear with no strobe leaves nothing behind
    a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (block_read_done && !scan_tick) |=> (cur_q.data == '0));
endmodule

// File: tb/tb_keyscan_irq.sv
module tb_keyscan_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic [19:0] key_raw = '0;
    logic        mode_8com = 1'b0;
    logic        int_pin_en = 1'b1;
    logic        int_act_high = 1'b0;
    logic        standby = 1'b0;
    logic        block_read_done = 1'b0;
    logic [7:0]  key_byte0, key_byte1, key_byte2, flag_byte;
    logic        int_level, int_oe, wake_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyscan_irq dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_raw(key_raw),
        .mode_8com(mode_8com), .int_pin_en(int_pin_en), .int_act_high(int_act_high),
        .standby(standby), .block_read_done(block_read_done),
        .key_byte0(key_byte0), .key_byte1(key_byte1), .key_byte2(key_byte2),
        .flag_byte(flag_byte), .int_level(int_level), .int_oe(int_oe),
        .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] img();
        return {key_byte2, key_byte1, key_byte0};
    endfunction

    task automatic strobe(input logic [19:0] keys, input logic clr);
        @(negedge clk);
        key_raw = keys;
        scan_tick = 1'b1;
        block_read_done = clr;
        @(negedge clk);
        scan_tick = 1'b0;
        block_read_done = 1'b0;
        #0.5;
    endtask

    task automatic read_clear();
        @(negedge clk);
        block_read_done = 1'b1;
        @(negedge clk);
        block_read_done = 1'b0;
        #0.5;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [19:0] expk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        chk("R1 image", img(), 24'h0);
        chk("R1 flag", flag_byte, 8'h00);
        chk("R1 pin inactive", int_level, 1'b1);

        // R2 R5 R9 sweep over every key in both modes
        for (int m = 0; m < 2; m++) begin
            mode_8com = m[0];
            for (int i = 0; i < 20; i++) begin
                read_clear();
                strobe(20'h1 << i, 1'b0);
                chk("R2 single strobe", img(), 24'h0);
                strobe(20'h1 << i, 1'b0);
                expk = (m == 1 && i >= 16) ? 20'h0 : (20'h1 << i);
                chk("R5 R9 placement", img(), {4'h0, expk});
                chk("R5 byte2 upper", key_byte2[7:4], 4'h0);
                chk("R6 flag", flag_byte, (expk != 0) ? 8'h80 : 8'h00);
                strobe(20'h0, 1'b0);
            end
        end
        mode_8com = 1'b0;

        // R3 accumulation
        read_clear();
        strobe(20'h00011, 1'b0); strobe(20'h00011, 1'b0); strobe(20'h0, 1'b0);
        strobe(20'h80200, 1'b0); strobe(20'h80200, 1'b0); strobe(20'h0, 1'b0);
        chk("R3 accumulate", img(), 24'h080211);

        // R7 clear
        read_clear();
        chk("R7 clear image", img(), 24'h0);
        chk("R7 clear flag", flag_byte, 8'h00);

        // R4 held key reported once
        strobe(20'h00040, 1'b0); strobe(20'h00040, 1'b0);
        read_clear();
        strobe(20'h00040, 1'b0); strobe(20'h00040, 1'b0); strobe(20'h00040, 1'b0);
        chk("R4 held not again", img(), 24'h0);
        strobe(20'h0, 1'b0);
        strobe(20'h00040, 1'b0); strobe(20'h00040, 1'b0);
        chk("R4 re-accept after release", img(), 24'h000040);
        strobe(20'h0, 1'b0);

        // R2 gap between presses
        read_clear();
        strobe(20'h00100, 1'b0); strobe(20'h0, 1'b0); strobe(20'h00100, 1'b0);
        chk("R2 gap not accepted", img(), 24'h0);
        strobe(20'h0, 1'b0);

        // R11 toggles without strobes
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            key_raw = (k % 2 == 1) ? 20'hFFFFF : 20'h0;
        end
        @(negedge clk); key_raw = 20'h0; #0.5;
        chk("R11 no strobe no change", img(), 24'h0);

        // R7 clear on the same strobe as an acceptance
        strobe(20'h00001, 1'b0); strobe(20'h00001, 1'b0); strobe(20'h0, 1'b0);
        strobe(20'h00008, 1'b0);
        strobe(20'h00008, 1'b1);
        chk("R7 same-strobe keep", img(), 24'h000008);
        chk("R7 same-strobe flag", flag_byte, 8'h80);
        strobe(20'h0, 1'b0);

        // R8 pin config sweep with flag set then clear
        for (int f = 0; f < 2; f++) begin
            if (f == 1) read_clear();
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                int_pin_en = c[0];
                int_act_high = c[1];
                #0.5;
                chk("R8 oe", int_oe, c[0]);
                chk("R8 level", int_level, (f == 0) ? c[1] : !c[1]);
            end
        end
        int_pin_en = 1'b1; int_act_high = 1'b1;

        // R10 standby
        strobe(20'h00002, 1'b0); strobe(20'h00002, 1'b0); strobe(20'h0, 1'b0);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); #0.5;
        chk("R10 image cleared", img(), 24'h0);
        chk("R10 flag cleared", flag_byte, 8'h00);
        chk("R10 pin inactive", int_level, 1'b0);
        chk("R10 no wake idle", wake_req, 1'b0);
        strobe(20'h00400, 1'b0); strobe(20'h00400, 1'b0);
        chk("R10 wake on key", wake_req, 1'b1);
        chk("R10 no accept", img(), 24'h0);
        mode_8com = 1'b1;
        @(negedge clk); key_raw = 20'h40000; #0.5;
        chk("R10 masked key no wake", wake_req, 1'b0);
        @(negedge clk); key_raw = 20'h0; standby = 1'b0; mode_8com = 1'b0; #0.5;
        chk("R10 wake low after exit", wake_req, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule